// File: doc/BRIEF.md
# Width-Scaled Memory Map Decoder

This block decodes the address of a small memory-mapped computer. It splits the address space into six regions: low memory, main RAM, a 32-byte register window, a host I/O buffer, video RAM and a reserved region. The region bases are fixed when the design is elaborated, and they are worked out from the address width `N`. The reserved region begins at `2^N - 2^(N/2)` and runs to the top of the address space. Video RAM sits in the 512 bytes just below it. The 1024-byte host I/O buffer sits directly below video RAM. As a result, the peripheral window moves with the square root of the address space.

The decoder produces a one-hot region select and the byte offset of the access inside the selected region. Both are combinational, so the device behind the decoder can answer in the same bus cycle with no wait states. Byte addresses are decoded at full resolution, so every byte of video RAM and of the register window can be selected on its own. The selects are gated by the read and write strobes, which means an idle cycle selects nothing. An access that lands in the reserved region raises a registered error pulse in the next cycle. A response for such accesses can be attached to this pulse later.

The 32-byte register window has a base set by a parameter. It must lie inside main RAM, and where it does, it takes priority over the RAM decode. Some parameter sets would break the layout: an odd or out-of-range width, a load address that is not below the host buffer base, or a register window that falls outside RAM. Any of these stops elaboration.

Top module: `memmap_decoder`

## Requirements
- R1: With a strobe active and the address below `LOAD_ADDR`, `region_sel` is 6'b000001 (bit 0, low memory) and `region_off` equals the address.
- R2: With a strobe active and the address from `LOAD_ADDR` up to one below the host buffer base, outside the register window, `region_sel` is 6'b000010 (bit 1, RAM) and `region_off` is the address minus `LOAD_ADDR`.
- R3: With a strobe active and the address in the 32 bytes from `REG_BASE`, `region_sel` is 6'b000100 (bit 2, registers) and `region_off` is the address minus `REG_BASE`. This overrides the RAM decode.
- R4: With a strobe active and the address in the 1024 bytes starting 1536 below the reserved base, `region_sel` is 6'b001000 (bit 3, host buffer) and `region_off` is the address minus that base.
- R5: With a strobe active and the address in the 512 bytes starting 512 below the reserved base, `region_sel` is 6'b010000 (bit 4, video RAM) and `region_off` is the address minus that base.
- R6: With a strobe active and the address at or above `2^N - 2^(N/2)`, `region_sel` is 6'b100000 (bit 5, reserved) and `region_off` is the address minus that base.
- R7: When neither `bus_rd` nor `bus_wr` is high, `region_sel` and `region_off` are all zero.
- R8: Whenever a strobe is high, exactly one bit of `region_sel` is set. `bus_rd` and `bus_wr` decode identically.
- R9: `decode_err` is high for exactly the cycle after each clock edge at which a strobed reserved access was present, and is low otherwise. It is low during reset.
- R10: Select and offset follow the address in the same cycle, with no register between address and select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the error pulse register |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| region_sel | output | 6 | One-hot region select: bit 0 low, 1 RAM, 2 registers, 3 host buffer, 4 video RAM, 5 reserved |
| region_off | output | ADDR_W | Byte offset within the selected region |
| decode_err | output | 1 | One-cycle pulse after a reserved-region access |

## Verification
The bench builds two instances. The first uses the default parameters: a 16-bit address with the load address at 0x0200, which places the register window at 0xF8E0, the host buffer at 0xF900, video RAM at 0xFD00 and the reserved region at 0xFF00. The second uses a 20-bit address with the load address at 0x400, which moves the reserved base to 0xFFC00 and grows the reserved region to 1 KB. Together the two instances test the formula at two widths, with a different `2^(N/2)` term in each. In both, every region boundary is probed on its first and last byte. Back-to-back reserved accesses show that the error pulse tracks each access cycle.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int     ADDR_W    = 16,
  parameter longint LOAD_ADDR = 64'h200,
  parameter longint REG_BASE  = (64'sd1 <<< ADDR_W) - (64'sd1 <<< (ADDR_W / 2)) - 1536 - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [5:0]        region_sel,
  output logic [ADDR_W-1:0] region_off,
  output logic              decode_err
);
  localparam longint RSVD_L = (64'sd1 <<< ADDR_W) - (64'sd1 <<< (ADDR_W / 2));
  localparam longint VRAM_L = RSVD_L - 512;
  localparam longint HBUF_L = RSVD_L - 1536;
  localparam longint REGE_L = REG_BASE + 32;

  generate
    if ((ADDR_W % 2) != 0 || ADDR_W < 12 || ADDR_W > 62) begin : g_bad_width
      $error("memmap_decoder: ADDR_W must be even and within 12..62");
    end
    if (LOAD_ADDR <= 0 || LOAD_ADDR >= HBUF_L) begin : g_bad_load
      $error("memmap_decoder: load address must lie above 0 and below the host buffer base");
    end
    if (REG_BASE < LOAD_ADDR || REGE_L > HBUF_L) begin : g_bad_regs
      $error("memmap_decoder: register window must lie inside main RAM");
    end
  endgenerate

  localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(LOAD_ADDR);
  localparam logic [ADDR_W-1:0] REG_A  = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] REGE_A = ADDR_W'(REGE_L);
  localparam logic [ADDR_W-1:0] HBUF_A = ADDR_W'(HBUF_L);
  localparam logic [ADDR_W-1:0] VRAM_A = ADDR_W'(VRAM_L);
  localparam logic [ADDR_W-1:0] RSVD_A = ADDR_W'(RSVD_L);

  logic              access;
  logic              in_low, in_regs, in_ram, in_hbuf, in_vram, in_rsvd;
  logic [5:0]        hit;
  logic [ADDR_W-1:0] base;

  assign access  = bus_rd | bus_wr;
  assign in_low  = bus_addr < LOAD_A;
  assign in_rsvd = bus_addr >= RSVD_A;
  assign in_vram = (bus_addr >= VRAM_A) && !in_rsvd;
  assign in_hbuf = (bus_addr >= HBUF_A) && (bus_addr < VRAM_A);
  assign in_regs = (bus_addr >= REG_A) && (bus_addr < REGE_A);
  assign in_ram  = !in_low && (bus_addr < HBUF_A) && !in_regs;
  assign hit     = {in_rsvd, in_vram, in_hbuf, in_regs, in_ram, in_low};

  always_comb begin
    if (in_rsvd)      base = RSVD_A;
    else if (in_vram) base = VRAM_A;
    else if (in_hbuf) base = HBUF_A;
    else if (in_regs) base = REG_A;
    else if (in_ram)  base = LOAD_A;
    else              base = '0;
  end

  assign region_sel = access ? hit : 6'b0;
  assign region_off = access ? (bus_addr - base) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) decode_err <= 1'b0;
    else        decode_err <= access && in_rsvd;
  end
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [5:0]        region_sel,
  input logic [ADDR_W-1:0] region_off,
  input logic              decode_err
);
  p_one_hot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> $countones(region_sel) == 1);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> (region_sel == 6'b0 && region_off == '0));

  p_low_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[0] |-> region_off == bus_addr);

  p_reg_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[2] |-> region_off < ADDR_W'(32));

  p_hbuf_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[3] |-> region_off < ADDR_W'(1024));

  p_vram_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[4] |-> region_off < ADDR_W'(512));

  p_err_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && region_sel[5]) |=> decode_err);

  p_err_only_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_rd || bus_wr) && region_sel[5]) |=> !decode_err);
endmodule

bind memmap_decoder memmap_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .region_sel(region_sel), .region_off(region_off), .decode_err(decode_err)
);

// File: tb/test_memmap_decoder.sv
module test_memmap_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] a_n = '0;
  logic [19:0] a_w = '0;
  logic [5:0]  sel_n, sel_w;
  logic [15:0] off_n;
  logic [19:0] off_w;
  logic        err_n, err_w;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  memmap_decoder i_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_n), .bus_rd(rd), .bus_wr(wr),
    .region_sel(sel_n), .region_off(off_n), .decode_err(err_n));

  memmap_decoder #(.ADDR_W(20), .LOAD_ADDR(64'h400)) i_memmap_decoder_wide (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_w), .bus_rd(rd), .bus_wr(wr),
    .region_sel(sel_w), .region_off(off_w), .decode_err(err_w));

  localparam logic [5:0] LOW = 6'b000001, RAM = 6'b000010, REGS = 6'b000100,
                         HBUF = 6'b001000, VRAM = 6'b010000, RSVD = 6'b100000;

  task automatic check(string tag, logic [19:0] got, logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic probe(bit wide, logic [19:0] addr, bit r, bit w,
                       logic [5:0] es, logic [19:0] eo, string tag);
    @(negedge clk);
    rd = r; wr = w;
    if (wide) a_w = addr; else a_n = addr[15:0];
    #1;
    check({tag, " sel"}, wide ? 20'(sel_w) : 20'(sel_n), 20'(es));
    check({tag, " off"}, wide ? off_w : 20'(off_n), eo);
    @(posedge clk); #1;
    check({tag, " R9 err"}, wide ? 20'(err_w) : 20'(err_n), 20'((r | w) && es == RSVD));
  endtask

  task automatic t_reset;
    check("R9 err in reset narrow", 20'(err_n), 20'd0);
    check("R9 err in reset wide", 20'(err_w), 20'd0);
  endtask

  task automatic t_narrow_map;
    probe(0, 20'h0000, 1, 0, LOW,  20'h0000, "R1 n low first");
    probe(0, 20'h01FF, 1, 0, LOW,  20'h01FF, "R1 n low last");
    probe(0, 20'h0200, 1, 0, RAM,  20'h0000, "R2 n ram first");
    probe(0, 20'h1234, 0, 1, RAM,  20'h1034, "R2 R8 n ram write");
    probe(0, 20'hF8DF, 1, 0, RAM,  20'hF6DF, "R2 n ram last");
    probe(0, 20'hF8E0, 1, 0, REGS, 20'h0000, "R3 n regs first");
    probe(0, 20'hF8FF, 0, 1, REGS, 20'h001F, "R3 n regs last");
    probe(0, 20'hF900, 1, 0, HBUF, 20'h0000, "R4 n hbuf first");
    probe(0, 20'hFCFF, 1, 0, HBUF, 20'h03FF, "R4 n hbuf last");
    probe(0, 20'hFD00, 0, 1, VRAM, 20'h0000, "R5 n vram first");
    probe(0, 20'hFEFF, 1, 0, VRAM, 20'h01FF, "R5 n vram last");
    probe(0, 20'hFF00, 1, 0, RSVD, 20'h0000, "R6 n rsvd first");
    probe(0, 20'hFFFF, 1, 1, RSVD, 20'h00FF, "R6 R8 n rsvd last");
  endtask

  task automatic t_wide_map;
    probe(1, 20'h003FF, 1, 0, LOW,  20'h003FF, "R1 w low last");
    probe(1, 20'h00400, 1, 0, RAM,  20'h00000, "R2 w ram first");
    probe(1, 20'hFF5DF, 1, 0, RAM,  20'hFF1DF, "R2 w ram last");
    probe(1, 20'hFF5E0, 0, 1, REGS, 20'h00000, "R3 w regs first");
    probe(1, 20'hFF600, 1, 0, HBUF, 20'h00000, "R4 w hbuf first");
    probe(1, 20'hFF9FF, 1, 0, HBUF, 20'h003FF, "R4 w hbuf last");
    probe(1, 20'hFFA00, 1, 0, VRAM, 20'h00000, "R5 w vram first");
    probe(1, 20'hFFBFF, 1, 0, VRAM, 20'h001FF, "R5 w vram last");
    probe(1, 20'hFFC00, 1, 0, RSVD, 20'h00000, "R6 w rsvd first");
    probe(1, 20'hFFFFF, 0, 1, RSVD, 20'h003FF, "R6 w rsvd last");
  endtask

  task automatic t_idle;
    probe(0, 20'hFF10, 0, 0, 6'b0, 20'h0, "R7 n idle on rsvd");
    probe(1, 20'hFF700, 0, 0, 6'b0, 20'h0, "R7 w idle on hbuf");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    rd = 1'b1; a_n = 16'h0100;
    #1 check("R10 n first addr", 20'(sel_n), 20'(LOW));
    a_n = 16'hFD10;
    #1 check("R10 n address change mid-cycle sel", 20'(sel_n), 20'(VRAM));
    check("R10 n address change mid-cycle off", 20'(off_n), 20'h10);
  endtask

  task automatic t_err_burst;
    probe(0, 20'hFF01, 1, 0, RSVD, 20'h0001, "R9 n burst 1");
    probe(0, 20'hFF80, 0, 1, RSVD, 20'h0080, "R9 n burst 2");
    probe(0, 20'h0300, 1, 0, RAM,  20'h0100, "R9 n burst end");
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rd = 1'b1; a_n = 16'hFF00; a_w = 20'hFFC00;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rd = 1'b0; rst_n = 1'b1;
    t_narrow_map();
    t_wide_map();
    t_idle();
    t_same_cycle();
    t_err_burst();
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule